// File: doc/BRIEF.md
# Two-Channel Change-Detect Input Port with Interrupt

This block samples two groups of general-purpose input pins into the system clock domain and shows their settled values through a small register file on a plain 32-bit word interface. Software reads the pin values from two read-only data words. It can ask to be told when a group changes.

A change of any bit in a channel, rising or falling, latches a pending flag for that channel. Two enable layers gate the pending flags onto one level-sensitive interrupt line toward an interrupt controller. The first is one master bit. The second is a mask with one bit per channel.

A pending flag stays set until software writes a 1 to it. Until then, further changes on that channel add no new event. Software therefore follows a fixed sequence: it reads the pending word, services the channels that are flagged, and writes the same bits back to clear them.

Top module: `gpio_change_irq`

## Requirements
- R1: While reset is asserted and right after it, every readable register returns 0 and `irqOut` is low.
- R2: Offset 0x000 returns the synchronized channel 1 inputs and offset 0x008 returns the synchronized channel 2 inputs, zero-extended. An input change is visible there two clock edges after it is applied. Writes to these offsets change nothing.
- R3: Offset 0x11C holds the master enable in bit 0. It can be read and written, and its other bits read 0.
- R4: Offset 0x128 holds the channel mask. Bit 0 is channel 1 and bit 1 is channel 2, and its other bits read 0.
- R5: Offset 0x120 holds the pending flags: bit 0 for channel 1, bit 1 for channel 2. A rising or falling change of any input bit of a channel sets its flag three edges after the input change. This happens even when the channel is masked or the master enable is 0.
- R6: A set pending flag stays set while no clearing write targets it, whatever the inputs do.
- R7: Writing 1 to a bit at 0x120 clears that pending flag on the next edge. Writing 0 leaves the flag unchanged.
- R8: If a change and a clearing write for the same channel fall in the same cycle, the flag stays set.
- R9: `irqOut` is high exactly when the master enable is 1 and at least one channel has both its flag and its mask bit set. It goes low on the edge after a write of 0 to the master enable.
- R10: Offsets outside the five above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| gpioIn1 | input | CH_WIDTH | Channel 1 asynchronous inputs |
| gpioIn2 | input | CH_WIDTH | Channel 2 asynchronous inputs |
| regAddr | input | 9 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the current offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the current offset (combinational) |
| irqOut | output | 1 | Level interrupt toward the controller |

## Verification
Two functions can land on the same edge: the detector setting a pending flag, and software clearing that flag with a 1 write. A directed sequence first latches channel 1's flag. It then toggles that channel and issues the clearing write in the cycle when the synchronized change reaches the detector. The flag must still read 1 afterwards and the interrupt must stay high. Random traffic mixes clearing writes with input toggles at random, so the bench's cycle model also judges many chance collisions on both channels, as well as clears that fall one cycle before or after a change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_CH     = 2;
  localparam int REG_ADDR_W = 9;
  localparam int REG_DATA_W = 32;

  localparam logic [REG_ADDR_W-1:0] OFF_DATA1 = 9'h000;
  localparam logic [REG_ADDR_W-1:0] OFF_DATA2 = 9'h008;
  localparam logic [REG_ADDR_W-1:0] OFF_GIE   = 9'h11C;
  localparam logic [REG_ADDR_W-1:0] OFF_STS   = 9'h120;
  localparam logic [REG_ADDR_W-1:0] OFF_IER   = 9'h128;

  // write strobes from register decode to the state holding datapath
  typedef struct packed {
    logic gieWr;
    logic ierWr;
    logic stsWr;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic             changed
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chainQ;
  logic [WIDTH-1:0]             prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainQ <= '0;
      prevQ  <= '0;
    end else begin
      chainQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chainQ[s] <= chainQ[s-1];
      prevQ <= chainQ[LAST];
    end
  end

  assign syncOut = chainQ[LAST];
  assign changed = (chainQ[LAST] != prevQ);

  // a change is reported exactly when the settled value moved on the last edge
  AST_CHANGE_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && changed) |-> !$stable(syncOut)); // R5
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int CH_WIDTH    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CH-1:0][CH_WIDTH-1:0]  chIn,
  input  regStrobe_t                       stb,
  input  logic [NUM_CH-1:0]                wrBits,
  output logic [NUM_CH-1:0][CH_WIDTH-1:0]  chSync,
  output logic                             gieQ,
  output logic [NUM_CH-1:0]                ierQ,
  output logic [NUM_CH-1:0]                stsQ,
  output logic                             irqOut
);
  logic [NUM_CH-1:0] chgDet;
  logic [NUM_CH-1:0] ackBits;

  assign ackBits = stb.stsWr ? wrBits : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gpio_irq_sync #(.WIDTH(CH_WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (chIn[c]),
      .syncOut (chSync[c]),
      .changed (chgDet[c])
    );

    // pending flag: set wins over clear
    always_ff @(posedge clk) begin
      if (!rstN)           stsQ[c] <= 1'b0;
      else if (chgDet[c])  stsQ[c] <= 1'b1;
      else if (ackBits[c]) stsQ[c] <= 1'b0;
    end

    AST_CHANGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      chgDet[c] |=> stsQ[c]); // R5
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (stb.stsWr && wrBits[c] && !chgDet[c]) |=> !stsQ[c]); // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!chgDet[c] && !(stb.stsWr && wrBits[c])) |=> $stable(stsQ[c])); // R6
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieQ <= 1'b0;
      ierQ <= '0;
    end else begin
      if (stb.gieWr) gieQ <= wrBits[0];
      if (stb.ierWr) ierQ <= wrBits;
    end
  end

  assign irqOut = gieQ & (|(stsQ & ierQ));

  AST_MASTER_OFF_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gieWr && !wrBits[0]) |=> !irqOut); // R9
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int CH_WIDTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [REG_ADDR_W-1:0]            regAddr,
  input  logic                             regWrEn,
  input  logic [NUM_CH-1:0][CH_WIDTH-1:0]  chSync,
  input  logic                             gieQ,
  input  logic [NUM_CH-1:0]                ierQ,
  input  logic [NUM_CH-1:0]                stsQ,
  output regStrobe_t                       stb,
  output logic [REG_DATA_W-1:0]            regRdData
);
  localparam int PAD_CH  = REG_DATA_W - CH_WIDTH;
  localparam int PAD_MSK = REG_DATA_W - NUM_CH;

  always_comb begin
    stb       = '0;
    stb.gieWr = regWrEn && (regAddr == OFF_GIE);
    stb.ierWr = regWrEn && (regAddr == OFF_IER);
    stb.stsWr = regWrEn && (regAddr == OFF_STS);
  end

  always_comb begin
    unique case (regAddr)
      OFF_DATA1: regRdData = {{PAD_CH{1'b0}}, chSync[0]};
      OFF_DATA2: regRdData = {{PAD_CH{1'b0}}, chSync[1]};
      OFF_GIE:   regRdData = {{(REG_DATA_W-1){1'b0}}, gieQ};
      OFF_STS:   regRdData = {{PAD_MSK{1'b0}}, stsQ};
      OFF_IER:   regRdData = {{PAD_MSK{1'b0}}, ierQ};
      default:   regRdData = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.gieWr, stb.ierWr, stb.stsWr})); // R10
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
  import gpio_irq_pkg::*;
#(
  parameter int CH_WIDTH    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CH_WIDTH-1:0]   gpioIn1,
  input  logic [CH_WIDTH-1:0]   gpioIn2,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  output logic                  irqOut
);
  regStrobe_t                      stb;
  logic [NUM_CH-1:0][CH_WIDTH-1:0] chIn;
  logic [NUM_CH-1:0][CH_WIDTH-1:0] chSync;
  logic                            gieQ;
  logic [NUM_CH-1:0]               ierQ;
  logic [NUM_CH-1:0]               stsQ;
  logic                            unusedWrBits;

  assign chIn         = {gpioIn2, gpioIn1};
  assign unusedWrBits = ^regWrData[REG_DATA_W-1:NUM_CH];

  gpio_irq_ctrl #(.CH_WIDTH(CH_WIDTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .chSync    (chSync),
    .gieQ      (gieQ),
    .ierQ      (ierQ),
    .stsQ      (stsQ),
    .stb       (stb),
    .regRdData (regRdData)
  );

  gpio_irq_datapath #(.CH_WIDTH(CH_WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .chIn   (chIn),
    .stb    (stb),
    .wrBits (regWrData[NUM_CH-1:0]),
    .chSync (chSync),
    .gieQ   (gieQ),
    .ierQ   (ierQ),
    .stsQ   (stsQ),
    .irqOut (irqOut)
  );

  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> !irqOut); // R1
endmodule

// File: tb/test_gpio_change_irq.sv
module test_gpio_change_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  gpioIn1 = '0;
  logic [7:0]  gpioIn2 = '0;
  logic [8:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  // cycle model built from the requirements
  logic [1:0][7:0] mS1, mS2, mPr;
  logic [1:0]      mSts, mIer;
  logic            mGie;

  always #5 clk = ~clk;

  gpio_change_irq i_gpio_change_irq (
    .clk(clk), .rstN(rstN), .gpioIn1(gpioIn1), .gpioIn2(gpioIn2),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] expRead(logic [8:0] a);
    case (a)
      9'h000:  return {24'h0, mS2[0]};
      9'h008:  return {24'h0, mS2[1]};
      9'h11C:  return {31'h0, mGie};
      9'h120:  return {30'h0, mSts};
      9'h128:  return {30'h0, mIer};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [8:0] a);
    case (a)
      9'h000, 9'h008: return "R2";
      9'h11C:         return "R3";
      9'h120:         return "R5/R6/R7";
      9'h128:         return "R4";
      default:        return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mS1 = '0; mS2 = '0; mPr = '0; mSts = '0; mIer = '0; mGie = 1'b0;
  endtask

  task automatic modelEdge();
    logic [1:0] ack;
    logic [1:0] chg;
    ack = (regWrEn && regAddr == 9'h120) ? regWrData[1:0] : 2'b00;
    for (int c = 0; c < 2; c++) chg[c] = (mS2[c] != mPr[c]);
    mSts = (mSts & ~ack) | chg;
    if (regWrEn && regAddr == 9'h11C) mGie = regWrData[0];
    if (regWrEn && regAddr == 9'h128) mIer = regWrData[1:0];
    mPr = mS2;
    mS2 = mS1;
    mS1 = {gpioIn2, gpioIn1};
  endtask

  // called just after a negedge with stimulus already applied
  task automatic stepCheck();
    #1;
    check(reqOf(regAddr), regRdData, expRead(regAddr));
    check("R9", {31'h0, irqOut}, {31'h0, mGie & (|(mSts & mIer))});
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic drive(logic [8:0] a, logic we, logic [31:0] wd);
    regAddr = a; regWrEn = we; regWrData = wd;
  endtask

  function automatic logic [8:0] pickAddr();
    case ($urandom_range(0, 7))
      0: return 9'h000;
      1: return 9'h008;
      2: return 9'h11C;
      3: return 9'h120;
      4: return 9'h128;
      5: return 9'h004;
      6: return 9'h124;
      default: return 9'h120;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state of every register and the line
    foreach (regAddr[i]) ; // no-op keeps style simple
    regAddr = 9'h000; #1 check("R1", regRdData, 32'h0);
    regAddr = 9'h11C; #1 check("R1", regRdData, 32'h0);
    regAddr = 9'h120; #1 check("R1", regRdData, 32'h0);
    regAddr = 9'h128; #1 check("R1", regRdData, 32'h0);
    check("R1", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();

    // R3/R4: enables, upper bits ignored on readback
    drive(9'h11C, 1'b1, 32'hFFFF_FFFF); stepCheck();
    drive(9'h128, 1'b1, 32'hFFFF_FFFD); stepCheck();
    drive(9'h11C, 1'b0, 0); stepCheck();
    drive(9'h128, 1'b0, 0); stepCheck();

    // R5: masked channel 2 still latches; falling edge on channel 1
    gpioIn2 = 8'h40; drive(9'h120, 1'b0, 0);
    repeat (4) stepCheck();
    check("R5", regRdData, 32'h2);
    check("R9", {31'h0, irqOut}, 32'h0);
    gpioIn1 = 8'h81; repeat (4) stepCheck();
    drive(9'h120, 1'b1, 32'h3); stepCheck();
    drive(9'h120, 1'b0, 0); #1 check("R7", regRdData, 32'h0);
    @(negedge clk);
    gpioIn1 = 8'h80; repeat (3) stepCheck();
    #1 check("R5", regRdData, 32'h1);
    check("R9", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    // R7: writing 0 keeps the flag
    drive(9'h120, 1'b1, 32'h0); stepCheck();
    drive(9'h120, 1'b0, 0); #1 check("R7", regRdData, 32'h1);
    @(negedge clk);
    // R6: further changes keep one pending flag
    gpioIn1 = 8'h00; repeat (4) stepCheck();
    #1 check("R6", regRdData, 32'h1);
    @(negedge clk);

    // R8: change and clear meet on one edge
    gpioIn1 = 8'h10; stepCheck(); stepCheck();
    drive(9'h120, 1'b1, 32'h1); stepCheck();
    drive(9'h120, 1'b0, 0); #1 check("R8", regRdData, 32'h1);
    check("R8", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    // R9: master off drops the line next edge
    drive(9'h11C, 1'b1, 32'h0); stepCheck();
    check("R9", {31'h0, irqOut}, 32'h0);
    // R10: unmapped write leaves enables alone
    drive(9'h124, 1'b1, 32'hFFFF_FFFF); stepCheck();
    drive(9'h128, 1'b0, 0); #1 check("R10", regRdData, 32'h1);
    @(negedge clk);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) < 2) gpioIn1 = gpioIn1 ^ (8'h1 << $urandom_range(0, 7));
      if ($urandom_range(0, 9) < 2) gpioIn2 = gpioIn2 ^ (8'h1 << $urandom_range(0, 7));
      drive(pickAddr(), ($urandom_range(0, 9) < 3), $urandom());
      stepCheck();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule